// File: doc/BRIEF.md
# PCIe Transaction Statistics Counter Bank

This block keeps traffic statistics for a PCIe transaction layer. Upstream logic has already parsed and classified each transaction. It presents one classified event per cycle on a valid/ready stream. Each event carries a direction (inbound or outbound), a traffic class (posted, non-posted or completion) and a byte count. For every accepted event, the block adds one to the packet counter for that direction and class. In the same cycle it adds the byte count to the matching byte counter. That gives twelve counters in all.

Counting never stops, and there is no enable or start/stop control. The event stream applies no back-pressure: `ev_ready` rises in the first clock after reset and then stays high. Software reaches the counters through a plain register port. A read returns a counter value one cycle after the access and does not disturb counting. Writing zero clears a counter. Any other write value is refused.

Top module: `pcie_txn_stats`

## Requirements
- R1: While reset is asserted, and right after it, every counter reads 0, `reg_rdata` is 0 and `ev_ready` is 0.
- R2: `ev_ready` is 1 from the first clock edge after reset is released and stays 1. An event is accepted when `ev_valid` and `ev_ready` are both high. An accepted event adds 1 to the packet counter selected by `ev_dir` and `ev_kind`. The `ev_dir` encoding is 0 for inbound and 1 for outbound. The `ev_kind` encoding is 0 for posted, 1 for non-posted and 2 for completion.
- R3: An accepted event adds `ev_bytes`, zero-extended, to the byte counter for the same direction and class.
- R4: An event whose `ev_kind` is 3 changes no counter.
- R5: Register offsets are fixed. Packet counters for inbound P, NP and C sit at 0x00, 0x10 and 0x18. Packet counters for outbound P, NP and C sit at 0x20, 0x28 and 0x30. Byte counters for inbound P, NP and C sit at 0x38, 0x40 and 0x48. Byte counters for outbound P, NP and C sit at 0x50, 0x58 and 0x60.
- R6: A read (`reg_en`=1, `reg_we`=0) puts the counter value from before that cycle's update on `reg_rdata` one clock later. A read never changes any counter. `reg_rdata` holds its value between reads.
- R7: A write of zero to a mapped offset clears that counter to 0 and leaves the other counters alone.
- R8: A write of any non-zero value leaves every counter unchanged.
- R9: When a zero write and an increment hit the same counter in the same cycle, the counter reads 0 afterwards.
- R10: A read of an unmapped offset returns 0. This includes 0x08 and any offset that is not a multiple of 8. A write to an unmapped offset changes nothing.
- R11: Counters are `CNT_W` bits wide and wrap modulo 2^`CNT_W` without any indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | A classified transaction event is present |
| ev_ready | output | 1 | Block accepts events; high from the first clock after reset |
| ev_dir | input | 1 | Event direction: 0 inbound, 1 outbound |
| ev_kind | input | 2 | Event class: 0 posted, 1 non-posted, 2 completion, 3 ignored |
| ev_bytes | input | BYTE_W | Byte count of the event |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | CNT_W | Write data; only zero is honoured |
| reg_rdata | output | CNT_W | Read data, valid the cycle after a read |

## Verification
The bench runs a behavioural model against the block on every clock. Single events of each direction and class are checked against hand-counted constants, which catches a swapped direction, a swapped class or a wrong offset. Dense random traffic mixed with reads at random offsets separates pre-update read values from post-update ones. It also catches any read that disturbs a count. Directed collisions place a zero write and an increment in the same cycle, and other runs write to unmapped or misaligned offsets. A long run of full-size byte counts is driven through a narrow counter width to show that the counters wrap.

// File: rtl/ptsb_pkg.sv
package ptsb_pkg;
  localparam int NUM_DIR   = 2;
  localparam int NUM_CLASS = 3;
  localparam int HALF      = NUM_DIR * NUM_CLASS;
  localparam int NUM_CTR   = 2 * HALF;
  localparam int IDX_W     = $clog2(NUM_CTR);

  typedef enum logic [1:0] {
    KIND_POSTED  = 2'd0,
    KIND_NONPOST = 2'd1,
    KIND_CPL     = 2'd2,
    KIND_RSVD    = 2'd3
  } kind_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } dir_e;
endpackage

// File: rtl/ptsb_event_decode.sv
module ptsb_event_decode
  import ptsb_pkg::*;
#(
  parameter int BYTE_W = 16,
  parameter int CNT_W  = 64
) (
  input  logic              fire,
  input  logic              dir,
  input  logic [1:0]        kind,
  input  logic [BYTE_W-1:0] bytes,
  output logic [NUM_CTR-1:0] inc,
  output logic [CNT_W-1:0]  amt [NUM_CTR]
);
  // Slot order: direction major, class minor; packet half first, byte half second.
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
      localparam int SLOT = d * NUM_CLASS + k;
      logic match;
      assign match            = fire && (dir == 1'(d)) && (kind == 2'(k));
      assign inc[SLOT]        = match;
      assign inc[HALF + SLOT] = match;
      assign amt[SLOT]        = CNT_W'(1);
      assign amt[HALF + SLOT] = CNT_W'(bytes);
    end
  end
endmodule

// File: rtl/ptsb_reg_decode.sv
module ptsb_reg_decode
  import ptsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64
) (
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_CTR-1:0] clr
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic              aligned;
  logic              zero_wr;

  assign slot    = reg_addr[ADDR_W-1:3];
  assign aligned = (reg_addr[2:0] == 3'd0);
  assign zero_wr = reg_en && reg_we && (reg_wdata == '0);

  // Offset 0x00 is slot 0; slot 1 (0x08) is a hole; slots 2..NUM_CTR map to 1..NUM_CTR-1.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (aligned && slot == '0) begin
      hit = 1'b1;
    end else if (aligned && slot >= SLOT_W'(2) && slot <= SLOT_W'(NUM_CTR)) begin
      hit = 1'b1;
      idx = IDX_W'(slot - SLOT_W'(1));
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_clr
    assign clr[i] = zero_wr && hit && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/ptsb_counter.sv
module ptsb_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [CNT_W-1:0] amt,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + amt;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt)); // R8

  AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (cnt == CNT_W'($past(cnt) + $past(amt)))); // R11
endmodule

// File: rtl/pcie_txn_stats.sv
module pcie_txn_stats
  import ptsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64,
  parameter int BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_dir,
  input  logic [1:0]        ev_kind,
  input  logic [BYTE_W-1:0] ev_bytes,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  logic               ready_q;
  logic               fire;
  logic [NUM_CTR-1:0] inc;
  logic [CNT_W-1:0]   amt [NUM_CTR];
  logic [NUM_CTR-1:0] clr;
  logic [CNT_W-1:0]   cnt [NUM_CTR];
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   rd_next;
  logic [CNT_W-1:0]   rdata_q;
  logic               rd_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign ev_ready = ready_q;
  assign fire     = ev_valid && ready_q;
  assign rd_acc   = reg_en && !reg_we;

  ptsb_event_decode #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_evdec (
    .fire  (fire),
    .dir   (ev_dir),
    .kind  (ev_kind),
    .bytes (ev_bytes),
    .inc   (inc),
    .amt   (amt)
  );

  ptsb_reg_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rdec (
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .idx       (idx),
    .clr       (clr)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    ptsb_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc[i]),
      .amt   (amt[i]),
      .clr   (clr[i]),
      .cnt   (cnt[i])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (hit && idx == IDX_W'(i)) rd_next = cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_next;
  end

  assign reg_rdata = rdata_q;

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> ev_ready); // R2

  AST_ONE_PKT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc[HALF-1:0])); // R2

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == KIND_RSVD) |-> (inc == '0)); // R4

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !hit) |=> (reg_rdata == '0)); // R10

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(reg_rdata)); // R6
endmodule

// File: tb/pcie_txn_stats_tb_top.sv
module pcie_txn_stats_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 12;
  localparam int BW = 10;
  localparam longint unsigned MASK = (64'd1 << CW) - 64'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic          ev_dir = 1'b0;
  logic [1:0]    ev_kind = 2'd0;
  logic [BW-1:0] ev_bytes = '0;
  logic          reg_en = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_txn_stats #(.ADDR_W(AW), .CNT_W(CW), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_dir(ev_dir),
    .ev_kind(ev_kind), .ev_bytes(ev_bytes),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  longint unsigned mdl [12];
  longint unsigned exp_rd = 0;
  bit    exp_rdy = 1'b0;
  bit    live = 1'b0;
  int    total = 0;
  int    bad = 0;
  string phase = "R1";

  function automatic int map_off(logic [AW-1:0] a);
    case (a)
      8'h00: return 0;  8'h10: return 1;  8'h18: return 2;
      8'h20: return 3;  8'h28: return 4;  8'h30: return 5;
      8'h38: return 6;  8'h40: return 7;  8'h48: return 8;
      8'h50: return 9;  8'h58: return 10; 8'h60: return 11;
      default: return -1;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_of(int i);
    return (i == 0) ? 8'h00 : AW'((i + 1) * 8);
  endfunction

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  // Reference model, updated at each rising edge from the inputs driven at the previous falling edge.
  always @(posedge clk) begin
    int ix;
    ix = map_off(reg_addr);
    if (!rst_n) begin
      foreach (mdl[i]) mdl[i] = 0;
      exp_rd  = 0;
      exp_rdy = 1'b0;
    end else begin
      if (reg_en && !reg_we) exp_rd = (ix >= 0) ? mdl[ix] : 0;
      if (ev_valid && exp_rdy && ev_kind != 2'd3) begin
        int s;
        s = int'(ev_dir) * 3 + int'(ev_kind);
        mdl[s]     = (mdl[s] + 1) & MASK;
        mdl[6 + s] = (mdl[6 + s] + longint'(ev_bytes)) & MASK;
      end
      if (reg_en && reg_we && ix >= 0 && reg_wdata == '0) mdl[ix] = 0;
      exp_rdy = 1'b1;
    end
    live = 1'b1;
  end

  always @(negedge clk) begin
    if (live) begin
      chk(reg_rdata == CW'(exp_rd), {phase, " rdata"}, reg_rdata, exp_rd);
      chk(ev_ready == exp_rdy, {phase, " ready"}, ev_ready, exp_rdy);
    end
  end

  task automatic cyc(bit v, bit d, logic [1:0] k, logic [BW-1:0] b,
                     bit en, bit we, logic [AW-1:0] a, logic [CW-1:0] wd);
    ev_valid = v; ev_dir = d; ev_kind = k; ev_bytes = b;
    reg_en = en; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    ev_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic send(bit d, logic [1:0] k, logic [BW-1:0] b);
    cyc(1'b1, d, k, b, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [CW-1:0] wd);
    cyc(1'b0, 1'b0, 2'd0, '0, 1'b1, 1'b1, a, wd);
  endtask

  task automatic rd_const(logic [AW-1:0] a, longint unsigned v, string tag);
    cyc(1'b0, 1'b0, 2'd0, '0, 1'b1, 1'b0, a, '0);
    chk(reg_rdata == CW'(v), tag, reg_rdata, v);
  endtask

  task automatic rd_all(string tag);
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 1'b0, 2'd0, '0, 1'b1, 1'b0, addr_of(i), '0);
      chk(reg_rdata == CW'(mdl[i]), tag, reg_rdata, mdl[i]);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 12; i++) wr(addr_of(i), '0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // R1: reset state
    phase = "R1";
    repeat (3) @(negedge clk);
    chk(ev_ready == 1'b0, "R1 ready low in reset", ev_ready, 0);
    chk(reg_rdata == '0, "R1 rdata zero in reset", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R2 ready high after reset", ev_ready, 1);
    rd_all("R1 counters zero after reset");

    // R5: fixed offsets with hand-counted values
    phase = "R5";
    send(1'b1, 2'd2, 10'd5);
    send(1'b1, 2'd2, 10'd6);
    send(1'b1, 2'd2, 10'd7);
    send(1'b0, 2'd1, 10'd9);
    rd_const(8'h30, 3, "R5 out C pkts at 0x30");
    rd_const(8'h60, 18, "R5 out C bytes at 0x60");
    rd_const(8'h10, 1, "R5 in NP pkts at 0x10");
    rd_const(8'h40, 9, "R5 in NP bytes at 0x40");
    rd_const(8'h00, 0, "R5 in P pkts untouched");

    // R2 / R3: every direction and class
    phase = "R2";
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 3; k++)
        send(d[0], 2'(k), BW'(11 * d + 3 * k + 1));
    rd_all("R2 R3 each class and direction");

    // R4: reserved class ignored
    phase = "R4";
    send(1'b0, 2'd3, 10'd100);
    send(1'b1, 2'd3, 10'd200);
    rd_all("R4 reserved class ignored");

    // R8: non-zero writes refused
    phase = "R8";
    rd_const(8'h30, 4, "R8 baseline 0x30");
    wr(8'h30, 12'h003);
    rd_const(8'h30, 4, "R8 write 3 refused");
    for (int i = 0; i < 12; i++) wr(addr_of(i), 12'h055);
    rd_all("R8 non-zero writes refused");

    // R7: zero write clears only its own counter
    phase = "R7";
    wr(8'h60, '0);
    rd_const(8'h60, 0, "R7 cleared 0x60");
    rd_const(8'h30, 4, "R7 neighbour 0x30 kept");
    rd_all("R7 others kept");

    // R9: clear and increment collide
    phase = "R9";
    clear_all();
    cyc(1'b1, 1'b0, 2'd0, 10'd7, 1'b1, 1'b1, 8'h00, '0);
    rd_const(8'h00, 0, "R9 clear beats increment");
    rd_const(8'h38, 7, "R9 byte counter still counted");

    // R10: unmapped offsets
    phase = "R10";
    rd_const(8'h08, 0, "R10 hole 0x08");
    rd_const(8'h68, 0, "R10 past end 0x68");
    rd_const(8'h3C, 0, "R10 misaligned 0x3C");
    rd_const(8'hF8, 0, "R10 high 0xF8");
    wr(8'h08, '0);
    wr(8'h3C, '0);
    wr(8'h39, '0);
    rd_const(8'h38, 7, "R10 unmapped writes ignored");

    // R6: read during increment returns pre-update value
    phase = "R6";
    cyc(1'b1, 1'b0, 2'd0, 10'd2, 1'b1, 1'b0, 8'h00, '0);
    chk(reg_rdata == '0, "R6 read sees pre-update value", reg_rdata, 0);
    rd_const(8'h00, 1, "R6 count not disturbed by read");
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 16);
      cyc(bit'($urandom % 2), bit'($urandom % 2), 2'($urandom % 4), BW'($urandom),
          (r < 6), 1'b0, (r < 4) ? addr_of(int'($urandom % 12)) : AW'($urandom), '0);
    end
    rd_all("R6 random traffic with reads");

    // R11: wrap
    phase = "R11";
    clear_all();
    ev_valid = 1'b1; ev_dir = 1'b0; ev_kind = 2'd0; ev_bytes = 10'd1023;
    repeat (4101) @(negedge clk);
    ev_valid = 1'b0;
    rd_const(8'h00, 5, "R11 packet counter wraps");
    rd_const(8'h38, 1019, "R11 byte counter wraps");

    finish_run();
  end
endmodule